// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial slave that lets an external host read and write a small bank of 8-bit configuration registers. The host drives a serial clock, an active-low select and a serial data line. Every transfer begins with one header byte: a direction flag followed by a 7-bit register address. One or more data bytes follow. Read data comes back either on a dedicated output line (4-wire operation) or on the shared data line (3-wire operation). The block drives each output through a separate value and enable pair, so the pad ring can build the tri-state buffers.

Register 0 is the port's own control byte. It selects 3-wire operation, selects least-significant-bit-first order, and holds a software reset. Each of these three flags can be set from either end of the byte, so the host can reach it whatever bit order is active. The serial pins are oversampled by the chip clock. The serial clock half-period must be at least two chip clock cycles longer than the synchronizer depth. Every register is brought out to the rest of the chip.

Top module: `spiCfgPort`

## Requirements
- R1: A transfer starts with a header byte. Its first bit on the wire is the direction flag (1 = read). The next 7 bits are the register address, sent in the active bit order. The data byte follows directly.
- R2: With bit order flag clear, bits travel most-significant first. With it set, they travel least-significant first, for both the header address and the data. A change of order or wire mode applies from the next header.
- R3: A write updates its register as soon as the last data bit is taken, while the select is still low.
- R4: Raising the select right after the header pauses the transfer, and the data byte follows after the select falls again. Raising it after a data byte ends the transfer. Raising it mid-byte abandons the byte without any write, and the next bits are read as a new header.
- R5: Register 0 control flags: 3-wire is data bit 7 or bit 0, LSB-first is bit 6 or bit 1, software reset is bit 5 or bit 2. A read returns each flag at both of its positions, and bits 4:3 read 0.
- R6: While the software reset flag is set, registers 1 and up hold their defaults and ignore writes. The default of register i is 0x10+i. Writing the flag back to 0 releases them. Register 0 is unaffected.
- R7: In 4-wire mode, read data leaves on sdoOut with sdoOe high only during the data phase of a read, and sdioOe stays low. In 3-wire mode, the data uses sdioOut/sdioOe and sdoOe stays low. The two enables are never high together.
- R8: Power-on reset or the reset pin returns every register, including register 0 (to 0x00), to its default.
- R9: Within one select-low period, the address moves after each data byte. It moves down by one in MSB-first order and up by one in LSB-first order, wrapping within 7 bits.
- R10: Addresses at or above the register count read as 0, and writes to them change nothing.
- R11: Input bits are taken on the serial clock rising edge. Read data changes after falling edges, so the first read bit is valid before the first rising edge of the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock that oversamples the serial pins |
| porRst | input | 1 | Power-on reset, active high |
| extRst | input | 1 | External reset pin, active high |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Select, active low |
| sdioIn | input | 1 | Serial data from the host |
| sdioOut | output | 1 | Read data for the shared line in 3-wire mode |
| sdioOe | output | 1 | Drive enable for the shared line |
| sdoOut | output | 1 | Read data for the dedicated output line |
| sdoOe | output | 1 | Drive enable for the dedicated output line |
| regsOut | output | NUM_REGS*8 | All register contents, register i at bits 8i+7:8i |

## Verification
The bound assertions check on every cycle that:
- the two output enables are never high together;
- each write strobe to a mapped register lands its byte in the next cycle;
- the address steps by exactly one in the direction set by the latched order;
- a set software reset keeps the bank at its defaults.

Other behaviours show only in scenarios driven at the pins:
- pausing versus abandoning a transfer on select;
- the mirrored control bits;
- a mode change taking effect at the next header;
- wrap into unmapped space;
- read data arriving on the correct pin in the correct order.

The bench drives each of these and compares the bytes it collects against a register model.

// File: rtl/spiCfgPkg.sv
package spiCfgPkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [0:0] {ST_HDR, ST_DATA} spiState_e;

  // strobes from the serial control to the datapath and register bank
  typedef struct packed {
    logic shiftIn;
    logic loadHdr;
    logic wrEn;
    logic advAddr;
    logic loadTx;
    logic shiftOut;
  } spiStrobes_t;

  function automatic logic [BYTE_W-1:0] regDefault(input int idx);
    return (idx == 0) ? 8'h00 : 8'(idx + 16);
  endfunction
endpackage

// File: rtl/spiCfgCtl.sv
module spiCfgCtl
  import spiCfgPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        hardRst,
  input  logic        sclk,
  input  logic        csN,
  input  logic        sdioIn,
  input  logic        cfgThreeWire,
  input  logic        cfgLsbFirst,
  input  logic        hdrRead,
  output spiStrobes_t stb,
  output logic        sampleBit,
  output logic        modeLsb,
  output logic        modeThreeWire,
  output logic        driveEn
);
  logic [SYNC_STAGES-1:0] sclkSync, csSync, dinSync;
  logic sclkPrev;
  logic sclkS, csHi;
  logic riseEdge, fallEdge, byteDone, dataDone;
  spiState_e state;
  logic [2:0] bitCnt;
  logic firstData, outValid, loadTxQ;

  always_ff @(posedge clk) begin
    if (hardRst) begin
      sclkSync <= '0;
      csSync   <= '1;
      dinSync  <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclk};
      csSync   <= {csSync[SYNC_STAGES-2:0], csN};
      dinSync  <= {dinSync[SYNC_STAGES-2:0], sdioIn};
      sclkPrev <= sclkS;
    end
  end

  assign sclkS     = sclkSync[SYNC_STAGES-1];
  assign csHi      = csSync[SYNC_STAGES-1];
  assign sampleBit = dinSync[SYNC_STAGES-1];

  assign riseEdge = ~csHi & sclkS & ~sclkPrev;
  assign fallEdge = ~csHi & ~sclkS & sclkPrev;
  assign byteDone = riseEdge & (bitCnt == 3'd7);
  assign dataDone = byteDone & (state == ST_DATA);

  always_comb begin
    stb.shiftIn  = riseEdge;
    stb.loadHdr  = byteDone & (state == ST_HDR);
    stb.wrEn     = dataDone & ~hdrRead;
    stb.advAddr  = dataDone;
    stb.loadTx   = loadTxQ;
    stb.shiftOut = fallEdge & (state == ST_DATA) & hdrRead;
  end

  assign driveEn = ~csHi & (state == ST_DATA) & hdrRead & outValid;

  always_ff @(posedge clk) begin
    if (hardRst) begin
      state         <= ST_HDR;
      bitCnt        <= '0;
      firstData     <= 1'b0;
      outValid      <= 1'b0;
      loadTxQ       <= 1'b0;
      modeLsb       <= 1'b0;
      modeThreeWire <= 1'b0;
    end else begin
      loadTxQ <= stb.loadHdr | dataDone;
      if (csHi) begin
        // a pause is only legal right after the header byte
        if (!(state == ST_DATA && bitCnt == 3'd0 && firstData)) begin
          state     <= ST_HDR;
          bitCnt    <= '0;
          firstData <= 1'b0;
          outValid  <= 1'b0;
        end
      end else begin
        if (riseEdge) bitCnt <= bitCnt + 3'd1;
        if (stb.loadHdr) begin
          state     <= ST_DATA;
          firstData <= 1'b1;
        end
        if (dataDone) firstData <= 1'b0;
        if (stb.shiftOut) outValid <= 1'b1;
      end
      // wire mode and order follow the control register until a header starts
      if (state == ST_HDR && bitCnt == 3'd0) begin
        modeLsb       <= cfgLsbFirst;
        modeThreeWire <= cfgThreeWire;
      end
    end
  end
endmodule

// File: rtl/spiCfgDp.sv
module spiCfgDp
  import spiCfgPkg::*;
(
  input  logic              clk,
  input  logic              hardRst,
  input  spiStrobes_t       stb,
  input  logic              sampleBit,
  input  logic              modeLsb,
  input  logic [BYTE_W-1:0] rdData,
  output logic [BYTE_W-1:0] rxNext,
  output logic [ADDR_W-1:0] addr,
  output logic              hdrRead,
  output logic              outBit
);
  logic [BYTE_W-1:0] rxShift, txShift;

  assign rxNext = modeLsb ? {sampleBit, rxShift[BYTE_W-1:1]}
                          : {rxShift[BYTE_W-2:0], sampleBit};

  always_ff @(posedge clk) begin
    if (hardRst) begin
      rxShift <= '0;
      txShift <= '0;
      addr    <= '0;
      hdrRead <= 1'b0;
      outBit  <= 1'b0;
    end else begin
      if (stb.shiftIn) rxShift <= rxNext;
      if (stb.loadHdr) begin
        // direction flag is the first bit on the wire in either order
        hdrRead <= modeLsb ? rxNext[0] : rxNext[BYTE_W-1];
        addr    <= modeLsb ? rxNext[BYTE_W-1:1] : rxNext[ADDR_W-1:0];
      end
      if (stb.advAddr) addr <= modeLsb ? addr + 1'b1 : addr - 1'b1;
      if (stb.loadTx) txShift <= rdData;
      if (stb.shiftOut) begin
        outBit  <= modeLsb ? txShift[0] : txShift[BYTE_W-1];
        txShift <= modeLsb ? {1'b0, txShift[BYTE_W-1:1]}
                           : {txShift[BYTE_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spiCfgRegs.sv
module spiCfgRegs
  import spiCfgPkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                     clk,
  input  logic                     hardRst,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [BYTE_W-1:0]        wrData,
  input  logic [ADDR_W-1:0]        rdAddr,
  output logic [BYTE_W-1:0]        rdData,
  output logic                     cfgThreeWire,
  output logic                     cfgLsbFirst,
  output logic [NUM_REGS*BYTE_W-1:0] regsOut
);
  localparam int IDX_W = (NUM_REGS > 2) ? $clog2(NUM_REGS) : 1;

  logic cfgSoftRst, bankRst;
  logic [BYTE_W-1:0] slots [NUM_REGS];

  assign bankRst = hardRst | cfgSoftRst;

  always_ff @(posedge clk) begin
    if (hardRst) begin
      cfgThreeWire <= 1'b0;
      cfgLsbFirst  <= 1'b0;
      cfgSoftRst   <= 1'b0;
    end else if (wrEn && wrAddr == '0) begin
      cfgThreeWire <= wrData[7] | wrData[0];
      cfgLsbFirst  <= wrData[6] | wrData[1];
      cfgSoftRst   <= wrData[5] | wrData[2];
    end
  end

  assign slots[0] = {cfgThreeWire, cfgLsbFirst, cfgSoftRst, 2'b00,
                     cfgSoftRst, cfgLsbFirst, cfgThreeWire};

  for (genvar i = 1; i < NUM_REGS; i++) begin : g_bank
    logic [BYTE_W-1:0] value;
    always_ff @(posedge clk) begin
      if (bankRst) value <= regDefault(i);
      else if (wrEn && int'(wrAddr) == i) value <= wrData;
    end
    assign slots[i] = value;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_out
    assign regsOut[i*BYTE_W +: BYTE_W] = slots[i];
  end

  assign rdData = (int'(rdAddr) < NUM_REGS) ? slots[rdAddr[IDX_W-1:0]] : '0;
endmodule

// File: rtl/spiCfgPort.sv
module spiCfgPort
  import spiCfgPkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       porRst,
  input  logic                       extRst,
  input  logic                       sclk,
  input  logic                       csN,
  input  logic                       sdioIn,
  output logic                       sdioOut,
  output logic                       sdioOe,
  output logic                       sdoOut,
  output logic                       sdoOe,
  output logic [NUM_REGS*BYTE_W-1:0] regsOut
);
  logic hardRst;
  spiStrobes_t ctlStb;
  logic sampleBit, modeLsb, modeThreeWire, driveEn;
  logic hdrRead, outBit, cfgThreeWire, cfgLsbFirst;
  logic [BYTE_W-1:0] rxNext, rdData;
  logic [ADDR_W-1:0] dpAddr;

  assign hardRst = porRst | extRst;

  spiCfgCtl #(.SYNC_STAGES(SYNC_STAGES)) uCtl (
    .clk(clk), .hardRst(hardRst), .sclk(sclk), .csN(csN), .sdioIn(sdioIn),
    .cfgThreeWire(cfgThreeWire), .cfgLsbFirst(cfgLsbFirst), .hdrRead(hdrRead),
    .stb(ctlStb), .sampleBit(sampleBit), .modeLsb(modeLsb),
    .modeThreeWire(modeThreeWire), .driveEn(driveEn)
  );

  spiCfgDp uDp (
    .clk(clk), .hardRst(hardRst), .stb(ctlStb), .sampleBit(sampleBit),
    .modeLsb(modeLsb), .rdData(rdData), .rxNext(rxNext), .addr(dpAddr),
    .hdrRead(hdrRead), .outBit(outBit)
  );

  spiCfgRegs #(.NUM_REGS(NUM_REGS)) uRegs (
    .clk(clk), .hardRst(hardRst), .wrEn(ctlStb.wrEn), .wrAddr(dpAddr),
    .wrData(rxNext), .rdAddr(dpAddr), .rdData(rdData),
    .cfgThreeWire(cfgThreeWire), .cfgLsbFirst(cfgLsbFirst), .regsOut(regsOut)
  );

  assign sdoOut  = outBit;
  assign sdioOut = outBit;
  assign sdoOe   = driveEn & ~modeThreeWire;
  assign sdioOe  = driveEn & modeThreeWire;
endmodule

// File: rtl/spiCfgPortChk.sv
module spiCfgPortChk
  import spiCfgPkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input logic                       clk,
  input logic                       hardRst,
  input logic                       sdoOe,
  input logic                       sdioOe,
  input spiStrobes_t                stb,
  input logic [ADDR_W-1:0]          wrAddr,
  input logic [BYTE_W-1:0]          wrData,
  input logic                       modeLsb,
  input logic [NUM_REGS*BYTE_W-1:0] regsOut
);
  // R7: only one output line is ever driven
  a_r7_single_driver: assert property (@(posedge clk) disable iff (hardRst)
    !(sdoOe && sdioOe));

  // R3: a write strobe to a mapped register lands the byte one cycle later
  a_r3_write_lands: assert property (@(posedge clk) disable iff (hardRst)
    (stb.wrEn && wrAddr != '0 && int'(wrAddr) < NUM_REGS && !regsOut[5])
    |=> regsOut[int'($past(wrAddr))*BYTE_W +: BYTE_W] == $past(wrData));

  // R9: the address steps by one in the direction of the latched order
  a_r9_addr_step: assert property (@(posedge clk) disable iff (hardRst)
    stb.advAddr |=> wrAddr == ($past(modeLsb) ? ADDR_W'($past(wrAddr) + 1'b1)
                                              : ADDR_W'($past(wrAddr) - 1'b1)));

  // R6: a set software reset keeps the bank at its defaults
  a_r6_soft_holds: assert property (@(posedge clk) disable iff (hardRst)
    regsOut[5] |=> (regsOut[2*BYTE_W-1 -: BYTE_W] == regDefault(1)) &&
                   (regsOut[NUM_REGS*BYTE_W-1 -: BYTE_W] == regDefault(NUM_REGS-1)));
endmodule

bind spiCfgPort spiCfgPortChk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .hardRst(hardRst), .sdoOe(sdoOe), .sdioOe(sdioOe), .stb(ctlStb),
  .wrAddr(dpAddr), .wrData(rxNext), .modeLsb(modeLsb), .regsOut(regsOut)
);

// File: tb/spiCfgPort_bench.sv
module spiCfgPort_bench;
  localparam int N = 8;
  localparam int H = 4;

  logic clk = 1'b0;
  logic porRst, extRst, sclk, csN, sdioIn;
  logic sdioOut, sdioOe, sdoOut, sdoOe;
  logic [N*8-1:0] regsOut;

  always #4 clk = ~clk;

  spiCfgPort #(.NUM_REGS(N)) u_spiCfgPort (
    .clk(clk), .porRst(porRst), .extRst(extRst), .sclk(sclk), .csN(csN),
    .sdioIn(sdioIn), .sdioOut(sdioOut), .sdioOe(sdioOe), .sdoOut(sdoOut),
    .sdoOe(sdoOe), .regsOut(regsOut)
  );

  typedef struct {
    logic [7:0] val;
    bit lsb;
    bit tw;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0, bad = 0;
  bit benchLsb = 0, benchTw = 0, benchSr = 0;
  logic [7:0] model [N];
  logic [7:0] acc;
  int nb = 0;

  function automatic logic [7:0] defVal(input int i);
    return (i == 0) ? 8'h00 : 8'(8'h10 + i);
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic void modelCtrl();
    model[0] = {benchTw, benchLsb, benchSr, 2'b00, benchSr, benchLsb, benchTw};
  endfunction

  function automatic void modelReset();
    for (int i = 0; i < N; i++) model[i] = defVal(i);
    benchTw = 0; benchLsb = 0; benchSr = 0;
  endfunction

  function automatic void modelWrite(input logic [6:0] a, input logic [7:0] d);
    if (a == 0) begin
      benchTw  = d[7] | d[0];
      benchLsb = d[6] | d[1];
      benchSr  = d[5] | d[2];
      modelCtrl();
      if (benchSr) for (int i = 1; i < N; i++) model[i] = defVal(i);
    end else if (int'(a) < N && !benchSr) begin
      model[a] = d;
    end
  endfunction

  function automatic logic [7:0] modelRead(input logic [6:0] a);
    return (int'(a) < N) ? model[a] : 8'h00;
  endfunction

  task automatic checkRegs(input string tag);
    for (int i = 0; i < N; i++) check8(tag, regsOut[i*8 +: 8], model[i]);
  endtask

  task automatic spiBit(input logic b);
    sdioIn = b;
    tick(H);
    sclk = 1'b1;
    tick(H);
    sclk = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) spiBit(benchLsb ? b[i] : b[7-i]);
  endtask

  task automatic sendHdr(input logic rw, input logic [6:0] a);
    spiBit(rw);
    for (int i = 0; i < 7; i++) spiBit(benchLsb ? a[i] : a[6-i]);
  endtask

  task automatic csDown();
    csN = 1'b0;
    tick(H);
  endtask

  task automatic csUp();
    tick(H);
    csN = 1'b1;
    tick(2*H);
  endtask

  task automatic pushExp(input logic [7:0] v, input string tag);
    expItem_t it;
    it.val = v; it.lsb = benchLsb; it.tw = benchTw; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    csDown();
    sendHdr(1'b0, a);
    sendByte(d);
    csUp();
    modelWrite(a, d);
  endtask

  task automatic rd(input logic [6:0] a, input string tag);
    pushExp(modelRead(a), tag);
    csDown();
    sendHdr(1'b1, a);
    sendByte(8'h00);
    csUp();
    total++;
    if (expQ.size() != 0) begin
      bad++;
      $display("FAIL %s: read bytes pending actual=%0d expected=0", tag, expQ.size());
      expQ.delete();
    end
  endtask

  // monitor: collects read bits at rising serial clock edges and scores them
  always @(posedge sclk) begin
    if (!csN && (sdoOe || sdioOe)) begin
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL R7: unexpected drive actual=1 expected=0");
      end else begin
        if (expQ[0].tw ? sdoOe : sdioOe) begin
          total++; bad++;
          $display("FAIL R7 %s: wrong pin driven actual sdoOe=%0b sdioOe=%0b expected threeWire=%0b",
                   expQ[0].tag, sdoOe, sdioOe, expQ[0].tw);
        end
        if (expQ[0].lsb) acc[nb] = expQ[0].tw ? sdioOut : sdoOut;
        else             acc[7-nb] = expQ[0].tw ? sdioOut : sdoOut;
        nb++;
        if (nb == 8) begin
          check8(expQ[0].tag, acc, expQ[0].val);
          void'(expQ.pop_front());
          nb = 0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    porRst = 1'b1; extRst = 1'b0; sclk = 1'b0; csN = 1'b1; sdioIn = 1'b0;
    modelReset();
    tick(5);
    porRst = 1'b0;
    tick(3);

    // R8 reset state, R7 no drive at idle
    checkRegs("R8 power-on defaults");
    check8("R7 idle sdoOe", {7'd0, sdoOe}, 8'h00);
    check8("R7 idle sdioOe", {7'd0, sdioOe}, 8'h00);

    // R1 R3 basic write and read, MSB-first 4-wire
    wr(7'd3, 8'hA7);
    checkRegs("R3 write reg3");
    rd(7'd3, "R1 R11 read reg3");
    rd(7'd0, "R5 ctrl read zero");

    // R3 register updates before select rises
    csDown();
    sendHdr(1'b0, 7'd4);
    sendByte(8'h3C);
    tick(4);
    check8("R3 update before select rise", regsOut[4*8 +: 8], 8'h3C);
    csUp();
    modelWrite(7'd4, 8'h3C);

    // R4 stall after header, write
    csDown();
    sendHdr(1'b0, 7'd2);
    csUp();
    tick(10);
    csDown();
    sendByte(8'h5A);
    csUp();
    modelWrite(7'd2, 8'h5A);
    checkRegs("R4 stalled write");

    // R4 stall after header, read
    pushExp(model[2], "R4 stalled read");
    csDown();
    sendHdr(1'b1, 7'd2);
    csUp();
    tick(10);
    csDown();
    sendByte(8'h00);
    csUp();

    // R4 abort mid-byte, then a fresh header
    csDown();
    sendHdr(1'b0, 7'd5);
    for (int i = 0; i < 4; i++) spiBit(1'b1);
    csUp();
    checkRegs("R4 aborted byte not written");
    wr(7'd5, 8'hC3);
    checkRegs("R4 new header after abort");

    // R4 select rise after a data byte ends the transfer
    csDown();
    sendHdr(1'b0, 7'd6);
    sendByte(8'h11);
    csUp();
    modelWrite(7'd6, 8'h11);
    rd(7'd6, "R4 fresh header after data byte");

    // R9 streaming down in MSB-first order
    csDown();
    sendHdr(1'b0, 7'd7);
    sendByte(8'h71);
    sendByte(8'h62);
    csUp();
    modelWrite(7'd7, 8'h71);
    modelWrite(7'd6, 8'h62);
    checkRegs("R9 streaming write down");
    pushExp(model[7], "R9 stream read first");
    pushExp(model[6], "R9 stream read second");
    csDown();
    sendHdr(1'b1, 7'd7);
    sendByte(8'h00);
    sendByte(8'h00);
    csUp();

    // R9 R10 wrap from address 0 into unmapped space
    pushExp(model[1], "R9 wrap reg1");
    pushExp(model[0], "R9 wrap reg0");
    pushExp(8'h00, "R10 wrap to unmapped reads zero");
    csDown();
    sendHdr(1'b1, 7'd1);
    sendByte(8'h00);
    sendByte(8'h00);
    sendByte(8'h00);
    csUp();

    // R10 unmapped write ignored, read zero
    wr(7'h50, 8'hFF);
    checkRegs("R10 unmapped write ignored");
    rd(7'h50, "R10 unmapped read");

    // R2 R5 switch to LSB-first through mirror bit 1
    wr(7'd0, 8'h02);
    check8("R5 mirror bit1 sets order", regsOut[7:0], 8'h42);
    csDown();
    sendHdr(1'b0, 7'd2);
    sendByte(8'hB4);
    sendByte(8'h96);
    csUp();
    modelWrite(7'd2, 8'hB4);
    modelWrite(7'd3, 8'h96);
    checkRegs("R2 R9 lsb-first streaming up");
    rd(7'd3, "R2 lsb-first read");

    // R7 3-wire, LSB-first
    wr(7'd0, 8'hC3);
    rd(7'd4, "R7 three-wire lsb read");
    rd(7'd0, "R5 ctrl readback both ends");

    // R5 R7 3-wire via bit 0, MSB-first
    wr(7'd0, 8'h01);
    rd(7'd3, "R7 three-wire msb read");
    rd(7'd0, "R5 mirror bit0 readback");
    wr(7'd0, 8'h00);
    rd(7'd5, "R7 back to four-wire");

    // R6 software reset via mirror bit 2
    wr(7'd0, 8'h04);
    checkRegs("R6 soft reset defaults");
    wr(7'd1, 8'h99);
    checkRegs("R6 write ignored while held");
    rd(7'd1, "R6 read default while held");
    wr(7'd0, 8'h00);
    wr(7'd1, 8'h99);
    checkRegs("R6 released bank writable");

    // R8 external reset returns everything, including order
    wr(7'd0, 8'h40);
    extRst = 1'b1;
    tick(3);
    extRst = 1'b0;
    tick(3);
    modelReset();
    checkRegs("R8 external reset defaults");
    rd(7'd2, "R8 msb-first after reset");

    tick(10);
    total++;
    if (expQ.size() != 0 || nb != 0) begin
      bad++;
      $display("FAIL R7: leftover read items actual=%0d expected=0", expQ.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule